// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the 8-bit status and control register of an asynchronous serial port. The CPU reaches it through a simple register bus: a read strobe, a write strobe and write data, with the current register value always present on the read data port. The receiver reports events as single-cycle pulses that set sticky flags. The transmitter supplies a transmit-end level and a shift-register idle indication. The block holds the transmit data register and moves its contents into the shift register when the transmitter is ready.

Software may clear the five sticky flags (bits 7 to 3) only by writing 0, and only after it has read that flag as 1 since the flag was last set. A hidden per-flag arm latch tracks this. Any hardware set of a flag drops the arm, so a stale read cannot clear a newer event. The transmit-empty flag is also cleared by any write to the transmit data register. It is held at 1 while the transmitter is disabled. It is set again when the data moves into the shift register.

Top module: `serial_status_reg`

## Requirements
- R1: After reset, and one cycle after `standby_i` is high, `rdata_o` equals 0x84 and `mpbt_o` is 0.
- R2: Writing 1 to any of bits 7 to 3 never sets that flag.
- R3: Writing 0 to a bit in 7..3 clears that flag only if a read with `rd_i` returned the flag as 1 in an earlier cycle since the flag was last set. Without such a read the write leaves the flag at 1.
- R4: A hardware set of a flag that is already 1 cancels an earlier qualifying read, so a following write of 0 is ignored until the flag is read again.
- R5: When a hardware set and a legal software clear of the same flag fall in one cycle, the flag is 1 afterwards.
- R6: Bit 2 (transmit end) and bit 1 (received multiprocessor bit) show `tx_end_i` and `rx_mpb_i` one cycle later, and register writes do not change them.
- R7: Bit 0 is read/write and drives `mpbt_o`.
- R8: Bit 7 (transmit empty) is 1 in the cycle after any cycle with `tx_en_i` low, even if the transmit data register was written in that cycle.
- R9: With `tx_en_i` high, a write on `tdr_wr_i` clears bit 7 on the next cycle and stores `tdr_wdata_i`.
- R10: When `tx_en_i` is high, bit 7 is 0 and `tsr_idle_i` is high, `tsr_load_o` is high for exactly one cycle with the stored data on `tsr_data_o`, and bit 7 is 1 on the next cycle.
- R11: Pulses on `rx_full_evt_i`, `rx_ovr_evt_i`, `rx_frm_evt_i` and `rx_par_evt_i` set bits 6, 5, 4 and 3, and these bits stay set until cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Synchronous load of the reset value |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register value |
| tdr_wr_i | input | 1 | Transmit data register write strobe |
| tdr_wdata_i | input | TDR_W | Transmit data register write data |
| tx_en_i | input | 1 | Transmitter enable |
| tsr_idle_i | input | 1 | Shift register ready for new data |
| tsr_load_o | output | 1 | One-cycle handoff pulse to the shift register |
| tsr_data_o | output | TDR_W | Data handed to the shift register |
| rx_full_evt_i | input | 1 | Receive-data-ready event |
| rx_ovr_evt_i | input | 1 | Overrun event |
| rx_frm_evt_i | input | 1 | Framing error event |
| rx_par_evt_i | input | 1 | Parity error event |
| tx_end_i | input | 1 | Transmitter finished level |
| rx_mpb_i | input | 1 | Received multiprocessor bit |
| mpbt_o | output | 1 | Multiprocessor bit to transmit |

## Verification
The embedded properties assume that the shift register raises `tsr_idle_i` only while it can accept a character. They also assume that each event input is a clean pulse sampled on the rising edge and that standby is not raised during reset. The bench drives every strobe and event on the falling edge for one full cycle and samples on the falling edge. This keeps all requests synchronous and separated by at least one cycle, except in the one scenario that deliberately puts a hardware set and a software clear in the same cycle.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   localparam int REG_W      = 8;
   localparam int N_STICKY   = 5;
   localparam int STICKY_LSB = 3;
   // bit positions decoded by software
   localparam int B_TXE   = 7;
   localparam int B_RXF   = 6;
   localparam int B_OVR   = 5;
   localparam int B_FRM   = 4;
   localparam int B_PAR   = 3;
   localparam int B_TEND  = 2;
   localparam int B_RMPB  = 1;
   localparam int B_TMPB  = 0;
   localparam logic [REG_W-1:0] RESET_VALUE = 8'h84;
endpackage

// File: rtl/ssr_flag_cell.sv
module ssr_flag_cell #(
   parameter bit INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic standby_i,
   input  logic hw_set_i,
   input  logic force_i,
   input  logic extra_clr_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wdata_bit_i,
   output logic flag_o
);
   logic flag_q, arm_q;
   logic set_any, sw_clr;

   assign set_any = hw_set_i | force_i;
   assign sw_clr  = wr_i & ~wdata_bit_i & arm_q;
   assign flag_o  = flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= INIT;
         arm_q  <= 1'b0;
      end else if (standby_i) begin
         flag_q <= INIT;
         arm_q  <= 1'b0;
      end else begin
         if (set_any)
            flag_q <= 1'b1;
         else if (sw_clr | extra_clr_i)
            flag_q <= 1'b0;

         if (set_any | sw_clr | extra_clr_i)
            arm_q <= 1'b0;
         else if (rd_i & flag_q)
            arm_q <= 1'b1;
      end
   end

   // R3
   unarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !arm_q && !extra_clr_i && !standby_i) |=> flag_q);
   // R5
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((hw_set_i || force_i) && !standby_i) |=> flag_q);
   // R3
   arm_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arm_q) |-> $past(rd_i && flag_q));
endmodule

// File: rtl/ssr_tx_handoff.sv
module ssr_tx_handoff #(
   parameter int TDR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tdr_wr_i,
   input  logic [TDR_W-1:0] tdr_wdata_i,
   input  logic             tx_en_i,
   input  logic             tsr_idle_i,
   input  logic             txe_i,
   output logic             load_o,
   output logic [TDR_W-1:0] data_o
);
   logic [TDR_W-1:0] tdr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tdr_q <= '0;
      else if (tdr_wr_i)
         tdr_q <= tdr_wdata_i;
   end

   assign load_o = tx_en_i & ~txe_i & tsr_idle_i;
   assign data_o = tdr_q;

   // R10
   load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |=> !load_o);
endmodule

// File: rtl/ssr_ro_follow.sv
module ssr_ro_follow #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic standby_i,
   input  logic tx_end_i,
   input  logic rx_mpb_i,
   output logic tend_o,
   output logic rmpb_o
);
   generate
      if (REGISTERED) begin : g_reg
         logic tend_q, rmpb_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tend_q <= 1'b1;
               rmpb_q <= 1'b0;
            end else if (standby_i) begin
               tend_q <= 1'b1;
               rmpb_q <= 1'b0;
            end else begin
               tend_q <= tx_end_i;
               rmpb_q <= rx_mpb_i;
            end
         end
         assign tend_o = tend_q;
         assign rmpb_o = rmpb_q;

         // R6
         tend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !standby_i |=> (tend_o == $past(tx_end_i)) && (rmpb_o == $past(rx_mpb_i)));
      end else begin : g_comb
         logic unused_ctl;
         assign unused_ctl = clk ^ rst_n ^ standby_i;
         assign tend_o = tx_end_i;
         assign rmpb_o = rx_mpb_i;
      end
   endgenerate
endmodule

// File: rtl/serial_status_reg.sv
module serial_status_reg
   import ssr_pkg::*;
#(
   parameter int TDR_W       = 8,
   parameter bit RO_REGISTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             standby_i,
   input  logic             rd_i,
   input  logic             wr_i,
   input  logic [7:0]       wdata_i,
   output logic [7:0]       rdata_o,
   input  logic             tdr_wr_i,
   input  logic [TDR_W-1:0] tdr_wdata_i,
   input  logic             tx_en_i,
   input  logic             tsr_idle_i,
   output logic             tsr_load_o,
   output logic [TDR_W-1:0] tsr_data_o,
   input  logic             rx_full_evt_i,
   input  logic             rx_ovr_evt_i,
   input  logic             rx_frm_evt_i,
   input  logic             rx_par_evt_i,
   input  logic             tx_end_i,
   input  logic             rx_mpb_i,
   output logic             mpbt_o
);
   localparam int TXE_IDX = B_TXE - STICKY_LSB;

   generate
      if (TDR_W < 5 || TDR_W > 9) begin : g_bad_width
         $error("serial_status_reg: TDR_W must be 5 to 9");
      end
      if (REG_W != 8) begin : g_bad_reg
         $error("serial_status_reg: register width must be 8");
      end
   endgenerate

   logic [N_STICKY-1:0] set_v, force_v, xclr_v, flag_v;
   logic tend, rmpb, load;
   logic mpbt_q;
   logic unused_wbits;

   assign unused_wbits = ^wdata_i[B_TEND:B_RMPB];

   assign set_v[B_TXE-STICKY_LSB] = load;
   assign set_v[B_RXF-STICKY_LSB] = rx_full_evt_i;
   assign set_v[B_OVR-STICKY_LSB] = rx_ovr_evt_i;
   assign set_v[B_FRM-STICKY_LSB] = rx_frm_evt_i;
   assign set_v[B_PAR-STICKY_LSB] = rx_par_evt_i;

   generate
      for (genvar i = 0; i < N_STICKY; i++) begin : g_flag
         assign force_v[i] = (i == TXE_IDX) ? ~tx_en_i  : 1'b0;
         assign xclr_v[i]  = (i == TXE_IDX) ? tdr_wr_i  : 1'b0;
         ssr_flag_cell #(.INIT(RESET_VALUE[i+STICKY_LSB])) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .standby_i   (standby_i),
            .hw_set_i    (set_v[i]),
            .force_i     (force_v[i]),
            .extra_clr_i (xclr_v[i]),
            .rd_i        (rd_i),
            .wr_i        (wr_i),
            .wdata_bit_i (wdata_i[i+STICKY_LSB]),
            .flag_o      (flag_v[i])
         );
      end
   endgenerate

   ssr_tx_handoff #(.TDR_W(TDR_W)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .tdr_wr_i    (tdr_wr_i),
      .tdr_wdata_i (tdr_wdata_i),
      .tx_en_i     (tx_en_i),
      .tsr_idle_i  (tsr_idle_i),
      .txe_i       (flag_v[TXE_IDX]),
      .load_o      (load),
      .data_o      (tsr_data_o)
   );

   ssr_ro_follow #(.REGISTERED(RO_REGISTER)) u_ro (
      .clk       (clk),
      .rst_n     (rst_n),
      .standby_i (standby_i),
      .tx_end_i  (tx_end_i),
      .rx_mpb_i  (rx_mpb_i),
      .tend_o    (tend),
      .rmpb_o    (rmpb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mpbt_q <= RESET_VALUE[B_TMPB];
      else if (standby_i)
         mpbt_q <= RESET_VALUE[B_TMPB];
      else if (wr_i)
         mpbt_q <= wdata_i[B_TMPB];
   end

   assign tsr_load_o = load;
   assign mpbt_o     = mpbt_q;
   assign rdata_o    = {flag_v, tend, rmpb, mpbt_q};

   // R8
   txoff_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en_i |=> rdata_o[B_TXE]);
   // R10
   load_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tsr_load_o && !standby_i) |=> rdata_o[B_TXE]);
   // R10
   load_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tsr_load_o |-> (tx_en_i && tsr_idle_i));
   // R1
   standby_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      standby_i |=> (rdata_o == RESET_VALUE));
endmodule

// File: tb/sim_serial_status_reg.sv
module sim_serial_status_reg;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic standby_i = 0, rd_i = 0, wr_i = 0, tdr_wr_i = 0, tx_en_i = 0, tsr_idle_i = 0;
   logic [7:0] wdata_i = 0, tdr_wdata_i = 0;
   logic rx_full_evt_i = 0, rx_ovr_evt_i = 0, rx_frm_evt_i = 0, rx_par_evt_i = 0;
   logic tx_end_i = 1, rx_mpb_i = 0;
   logic [7:0] rdata_o, tsr_data_o;
   logic tsr_load_o, mpbt_o;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   serial_status_reg u0 (.*);

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd_pulse();
      rd_i = 1; cyc(); rd_i = 0;
   endtask

   task automatic wr(input logic [7:0] d);
      wr_i = 1; wdata_i = d; cyc(); wr_i = 0;
   endtask

   task automatic t_reset();
      chk("R1 reset value", rdata_o, 8'h84);
      chk("R1 reset mpbt", mpbt_o, 0);
      chk("R10 no load at reset", tsr_load_o, 0);
   endtask

   task automatic t_rx_events();
      rx_full_evt_i = 1; rx_par_evt_i = 1; cyc();
      rx_full_evt_i = 0; rx_par_evt_i = 0; rx_ovr_evt_i = 1; cyc();
      rx_ovr_evt_i = 0; rx_frm_evt_i = 1; cyc();
      rx_frm_evt_i = 0; cyc();
      chk("R11 sticky flags set", rdata_o, 8'hFC);
      wr(8'h80);
      chk("R3 unread write ignored", rdata_o, 8'hFC);
      rd_pulse();
      wr(8'h80);
      chk("R3 read then clear", rdata_o, 8'h84);
      wr(8'hF8);
      chk("R2 write one no set", rdata_o, 8'h84);
   endtask

   task automatic t_rearm();
      rx_full_evt_i = 1; cyc(); rx_full_evt_i = 0;
      rd_pulse();
      rx_full_evt_i = 1; cyc(); rx_full_evt_i = 0;
      wr(8'h80);
      chk("R4 reset of arm by new set", rdata_o, 8'hC4);
      rd_pulse();
      wr(8'h80);
      chk("R4 clear after fresh read", rdata_o, 8'h84);
   endtask

   task automatic t_set_wins();
      rx_ovr_evt_i = 1; cyc(); rx_ovr_evt_i = 0;
      rd_pulse();
      rx_ovr_evt_i = 1; wr_i = 1; wdata_i = 8'h80; cyc();
      rx_ovr_evt_i = 0; wr_i = 0;
      chk("R5 set beats clear", rdata_o, 8'hA4);
      rd_pulse();
      wr(8'h80);
      chk("R5 later clear", rdata_o, 8'h84);
   endtask

   task automatic t_ro();
      tx_end_i = 0; cyc();
      chk("R6 tend follows", rdata_o, 8'h80);
      wr(8'h84);
      chk("R6 tend write ignored", rdata_o, 8'h80);
      rx_mpb_i = 1; cyc();
      chk("R6 rmpb follows", rdata_o, 8'h82);
      wr(8'h80);
      chk("R6 rmpb write ignored", rdata_o, 8'h82);
      tx_end_i = 1; rx_mpb_i = 0; cyc();
      chk("R6 restore", rdata_o, 8'h84);
   endtask

   task automatic t_mpbt();
      wr(8'hF9);
      chk("R7 mpbt set reg", rdata_o, 8'h85);
      chk("R7 mpbt set pin", mpbt_o, 1);
      wr(8'hF8);
      chk("R7 mpbt clear", {rdata_o, 7'b0, mpbt_o}, {8'h84, 8'h00});
   endtask

   task automatic t_tx();
      tdr_wr_i = 1; tdr_wdata_i = 8'h11; cyc(); tdr_wr_i = 0;
      chk("R8 tdr write while disabled", rdata_o, 8'h84);
      tx_en_i = 1; cyc();
      tdr_wr_i = 1; tdr_wdata_i = 8'hA5; cyc(); tdr_wr_i = 0;
      chk("R9 tdr write clears empty", rdata_o, 8'h04);
      chk("R9 no load while busy", tsr_load_o, 0);
      tsr_idle_i = 1; #1;
      chk("R10 load pulse", tsr_load_o, 1);
      chk("R10 load data", tsr_data_o, 8'hA5);
      cyc();
      chk("R10 load ends", tsr_load_o, 0);
      chk("R10 empty after load", rdata_o, 8'h84);
      tsr_idle_i = 0;
      rd_pulse();
      wr(8'h78);
      chk("R3 legal clear of empty", rdata_o, 8'h04);
      tx_en_i = 0; cyc();
      chk("R8 disable forces empty", rdata_o, 8'h84);
   endtask

   task automatic t_standby();
      rx_frm_evt_i = 1; cyc(); rx_frm_evt_i = 0;
      wr(8'hF9);
      chk("R1 pre standby", rdata_o, 8'h95);
      standby_i = 1; cyc(); standby_i = 0;
      chk("R1 standby value", rdata_o, 8'h84);
      chk("R1 standby mpbt", mpbt_o, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (8 * 200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      cyc(); cyc();
      rst_n = 1;
      cyc();
      t_reset();
      t_rx_events();
      t_rearm();
      t_set_wins();
      t_ro();
      t_mpbt();
      t_tx();
      t_standby();
      cyc();
      finish_run();
   end
endmodule